// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Word Sequencer

This block carries 32-bit words between an on-chip request port and a narrow external bus on which address and data share the same 16 wires. Each request names a word address, a direction and, for writes, the data. The block then runs a sequence of bus phases. An address phase holds `ale` high while the address sits on the shared wires, so an external latch can capture it when `ale` falls. Data phases follow, with `rd_n` or `wr_n` held low.

Two bus geometries are selectable per request. In the byte-wide mode, one word takes four byte phases, least significant byte first. The low eight bits of the byte address ride on the upper half of the bus during each byte phase. An address phase is paid only when the latched upper address can no longer be trusted: the first word after reset, a change of mode, a non-sequential word, or a step into a new 256-byte page. In the halfword mode, every word always costs two address phases and two halfword phases. The data phase length and an optional idle cycle after each data phase are programmable per request.

Top module: `mbs_seq`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `rsp_valid` is 0.
- R2: An address phase lasts ALE_CYC cycles (default 3) with `ale` high and `ad_oe` = 2'b11. It drives byte address bits [23:8] in byte mode, and bits [15:0] of the halfword's byte address in halfword mode. Byte address = {word address, 2'b00}.
- R3: In byte mode (`cfg_wide` = 0), a word uses four data phases for byte offsets 0,1,2,3 in that order. Each phase puts the byte address bits [7:0] on AD[15:8] and data byte k (bits 8k+7:8k) on AD[7:0].
- R4: In byte mode, a word gets exactly one address phase if it is the first word after reset, or if its word address is not the previous word address plus one, or if its page (byte address bits [23:8]) differs from the previous word's page. Otherwise it gets none.
- R5: In halfword mode (`cfg_wide` = 1), every word uses address, data, address, data, in that order. The low halfword goes first at byte offset 0, then the high halfword at byte offset 2. The full 16 bits of AD carry data.
- R6: A word whose mode differs from the previous word's mode always begins with an address phase.
- R7: A data phase lasts `cfg_dur` cycles, where a value of 0 acts as 1. The strobe for the direction stays low for the whole phase.
- R8: With `cfg_hold` = 1, one cycle with both strobes high, `ale` low and `ad_oe` = 0 follows every data phase. With `cfg_hold` = 0, no such cycle is added.
- R9: In read data phases `ad_oe` is 2'b10 in byte mode (only the address lane driven) and 2'b00 in halfword mode. The input is sampled on the last cycle of each phase. `rsp_rdata` holds the assembled word in the same lane order as R3 and R5.
- R10: `req_ready` is high only while no word is in progress. `rsp_valid` pulses for one cycle, right after the last bus cycle of the word. Counted from the accepting clock edge, it appears in cycle 3·(address phases) + (data phases)·(phase length + hold) + 1.
- R11: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 = halfword bus mode, 0 = byte bus mode; sampled at request acceptance |
| cfg_dur | input | DUR_W | Data phase length in cycles (0 acts as 1); sampled at acceptance |
| cfg_hold | input | 1 | Adds one idle cycle after each data phase; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 22 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read word, valid with rsp_valid on reads |
| ad_o | output | 16 | Shared address/data bus, outgoing value |
| ad_oe | output | 2 | Output enables: bit 1 for AD[15:8], bit 0 for AD[7:0] |
| ad_i | input | 16 | Shared bus, incoming value |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Runs of consecutive word addresses in byte mode separate a design that skips the address phase correctly from one that pays it every word. The same runs, when they cross a multiple of 64 words, expose a missed page crossing. Jumps to unrelated addresses and switches between the two modes expose a stale latched address. An external memory model built from the observed address phases returns address-derived data, so a wrong address, a wrong lane or a wrong byte order shows up as wrong read data or a wrong stored byte. Sweeping the phase length, including 0, together with the hold option separates each timing term in the completion latency.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int AD_W     = 16;
    localparam int BADDR_W  = 24;
    localparam int WADDR_W  = BADDR_W - 2;
    localparam int PAGE_LSB = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALE  = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_e;
endpackage

// File: rtl/mbs_page_track.sv
module mbs_page_track
    import mbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               wide,
    input  logic [WADDR_W-1:0] waddr,
    output logic               need_ale
);
    localparam int PG_LO = PAGE_LSB - 2;

    typedef struct packed {
        logic               known;
        logic               wide;
        logic [WADDR_W-1:0] waddr;
    } trk_t;

    trk_t d, q;
    logic [WADDR_W-1:0] next_seq;

    always_comb begin
        next_seq = q.waddr + 1'b1;
        need_ale = !q.known || wide || (wide != q.wide) || (waddr != next_seq)
                   || (waddr[WADDR_W-1:PG_LO] != q.waddr[WADDR_W-1:PG_LO]);
        d = q;
        if (acc) begin
            d.known = 1'b1;
            d.wide  = wide;
            d.waddr = waddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mbs_lane_mux.sv
module mbs_lane_mux
    import mbs_pkg::*;
(
    input  bus_st_e            st,
    input  logic               wide,
    input  logic               write,
    input  logic [1:0]         beat,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [31:0]        wdata,
    output logic [AD_W-1:0]    ad_o,
    output logic [1:0]         ad_oe,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);
    logic [BADDR_W-1:0] cur;
    logic [7:0]         byte_sel;
    logic [15:0]        half_sel;

    always_comb begin
        cur      = {waddr, (wide ? {beat[0], 1'b0} : beat)};
        byte_sel = wdata[8*beat +: 8];
        half_sel = beat[0] ? wdata[31:16] : wdata[15:0];
        ad_o     = '0;
        ad_oe    = 2'b00;
        ale      = 1'b0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        case (st)
            ST_ALE: begin
                ale   = 1'b1;
                ad_oe = 2'b11;
                ad_o  = wide ? cur[15:0] : cur[BADDR_W-1:PAGE_LSB];
            end
            ST_DATA: begin
                rd_n = write;
                wr_n = !write;
                if (wide) begin
                    ad_o  = write ? half_sel : '0;
                    ad_oe = write ? 2'b11 : 2'b00;
                end else begin
                    ad_o  = {cur[7:0], (write ? byte_sel : 8'h00)};
                    ad_oe = write ? 2'b11 : 2'b10;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
#(
    parameter int ALE_CYC = 3,
    parameter int DUR_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic [DUR_W-1:0]   cfg_dur,
    input  logic               cfg_hold,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WADDR_W-1:0] req_addr,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [AD_W-1:0]    ad_o,
    output logic [1:0]         ad_oe,
    input  logic [AD_W-1:0]    ad_i,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);
    localparam int ACW   = $clog2(ALE_CYC + 1);
    localparam int CNT_W = (DUR_W > ACW) ? DUR_W : ACW;
    localparam logic [CNT_W-1:0] ALE_LOAD = CNT_W'(ALE_CYC - 1);

    typedef struct packed {
        bus_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         beat;
        logic [WADDR_W-1:0] waddr;
        logic               write;
        logic               wide;
        logic [DUR_W-1:0]   dur;
        logic               hold;
        logic [31:0]        wdata;
        logic [31:0]        rdata;
        logic               rsp;
    } seq_t;

    seq_t d, q;
    logic need_ale;
    logic acc;
    logic advance;
    logic last;
    logic [CNT_W-1:0] q_dur_m1;
    logic [CNT_W-1:0] in_dur_m1;

    assign req_ready = (q.st == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign rsp_valid = q.rsp;
    assign rsp_rdata = q.rdata;

    mbs_page_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wide     (cfg_wide),
        .waddr    (req_addr),
        .need_ale (need_ale)
    );

    mbs_lane_mux u_mux (
        .st    (q.st),
        .wide  (q.wide),
        .write (q.write),
        .beat  (q.beat),
        .waddr (q.waddr),
        .wdata (q.wdata),
        .ad_o  (ad_o),
        .ad_oe (ad_oe),
        .ale   (ale),
        .rd_n  (rd_n),
        .wr_n  (wr_n)
    );

    always_comb begin
        d         = q;
        d.rsp     = 1'b0;
        advance   = 1'b0;
        q_dur_m1  = (q.dur == '0)   ? '0 : CNT_W'(q.dur - 1'b1);
        in_dur_m1 = (cfg_dur == '0) ? '0 : CNT_W'(cfg_dur - 1'b1);
        last      = q.wide ? q.beat[0] : (q.beat == 2'd3);
        case (q.st)
            ST_IDLE: begin
                if (acc) begin
                    d.waddr = req_addr;
                    d.write = req_write;
                    d.wdata = req_wdata;
                    d.wide  = cfg_wide;
                    d.dur   = cfg_dur;
                    d.hold  = cfg_hold;
                    d.beat  = 2'd0;
                    if (need_ale) begin
                        d.st  = ST_ALE;
                        d.cnt = ALE_LOAD;
                    end else begin
                        d.st  = ST_DATA;
                        d.cnt = in_dur_m1;
                    end
                end
            end
            ST_ALE: begin
                if (q.cnt == '0) begin
                    d.st  = ST_DATA;
                    d.cnt = q_dur_m1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_DATA: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    if (!q.write) begin
                        if (q.wide) d.rdata[16*q.beat[0] +: 16] = ad_i;
                        else        d.rdata[8*q.beat +: 8]      = ad_i[7:0];
                    end
                    if (q.hold) d.st = ST_HOLD;
                    else        advance = 1'b1;
                end
            end
            ST_HOLD: advance = 1'b1;
            default: d.st = ST_IDLE;
        endcase
        if (advance) begin
            if (last) begin
                d.st  = ST_IDLE;
                d.rsp = 1'b1;
            end else begin
                d.beat = q.beat + 1'b1;
                if (q.wide) begin
                    d.st  = ST_ALE;
                    d.cnt = ALE_LOAD;
                end else begin
                    d.st  = ST_DATA;
                    d.cnt = q_dur_m1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int ALE_CYC = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        ale,
    input logic        rd_n,
    input logic        wr_n,
    input logic [15:0] ad_o,
    input logic [1:0]  ad_oe
);
    logic [7:0] ale_run;

    always_ff @(posedge clk) begin
        if (!rst_n)   ale_run <= '0;
        else if (ale) ale_run <= ale_run + 1'b1;
        else          ale_run <= '0;
    end

    assert_ale_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ale_run == 8'(ALE_CYC)));

    assert_ale_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |-> ($stable(ad_o) && ad_oe == 2'b11));

    assert_read_lane_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe[0]);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));
endmodule

bind mbs_seq mbs_checker #(.ALE_CYC(ALE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe)
);

// File: tb/tb_mbs_seq.sv
module tb_mbs_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ALE_N      = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [3:0]  cfg_dur = 4'd3;
    logic        cfg_hold = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [15:0] ad_o;
    logic [1:0]  ad_oe;
    logic [15:0] ad_i = '0;
    logic        ale, rd_n, wr_n;

    int checks = 0;
    int errors = 0;
    int ale_cnt = 0;
    logic ale_prev = 1'b0;
    logic [15:0] latch = '0;
    logic [7:0]  mem8  [int unsigned];
    logic [15:0] mem16 [int unsigned];

    logic        m_known = 1'b0;
    logic        m_wide = 1'b0;
    logic [21:0] m_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbs_seq #(.ALE_CYC(ALE_N), .DUR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_dur(cfg_dur),
        .cfg_hold(cfg_hold), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ad_o(ad_o),
        .ad_oe(ad_oe), .ad_i(ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    function automatic logic [7:0] h8(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] h16(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h3C};
    endfunction

    function automatic logic [7:0] rd8(input logic [23:0] a);
        return mem8.exists(a) ? mem8[a] : h8(a);
    endfunction

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return mem16.exists(a) ? mem16[a] : h16(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // External memory and lane monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale && !ale_prev) ale_cnt++;
            if (ale) begin
                latch = ad_o;
                chk(ad_oe == 2'b11, "R2 address phase oe", 32'(ad_oe), 32'h3);
            end
            if (!rd_n) begin
                chk(ad_oe == (cfg_wide ? 2'b00 : 2'b10), "R9 read lane enables",
                    32'(ad_oe), cfg_wide ? 32'h0 : 32'h2);
                ad_i = cfg_wide ? rd16(latch) : {8'h00, rd8({latch, ad_o[15:8]})};
            end
            if (!wr_n) begin
                if (cfg_wide) mem16[32'(latch)] = ad_o;
                else          mem8[32'({latch, ad_o[15:8]})] = ad_o[7:0];
            end
        end
        ale_prev = ale;
    end

    task automatic xfer(input logic wide, input logic [3:0] dur, input logic hold,
                        input logic wr, input logic [21:0] wa, input logic [31:0] wd);
        int exp_ale, exp_lat, lat, nd, de;
        logic [23:0] ba;
        logic [31:0] exp_rd;
        logic need;
        need = !m_known || wide || (wide != m_wide) || (wa != m_last + 22'd1)
               || (wa[21:6] != m_last[21:6]);
        exp_ale = wide ? 2 : (need ? 1 : 0);
        m_known = 1'b1; m_wide = wide; m_last = wa;
        nd = wide ? 2 : 4;
        de = (dur == 0) ? 1 : int'(dur);
        exp_lat = exp_ale * ALE_N + nd * (de + int'(hold)) + 1;
        ba = {wa, 2'b00};
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready while idle", 32'(req_ready), 32'h1);
        ale_cnt   = 0;
        cfg_wide  = wide; cfg_dur = dur; cfg_hold = hold;
        req_addr  = wa; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R10/R7/R8 completion latency", 32'(lat), 32'(exp_lat));
        chk(ale_cnt == exp_ale, wide ? "R5/R6 address phase count" : "R4/R6 address phase count",
            32'(ale_cnt), 32'(exp_ale));
        if (wr) begin
            if (wide)
                exp_rd = {rd16(ba[15:0] + 16'd2), rd16(ba[15:0])};
            else
                exp_rd = {rd8(ba + 24'd3), rd8(ba + 24'd2), rd8(ba + 24'd1), rd8(ba)};
            chk(exp_rd == wd, wide ? "R5 stored halfwords" : "R3 stored bytes", exp_rd, wd);
        end else begin
            if (wide)
                exp_rd = {rd16(ba[15:0] + 16'd2), rd16(ba[15:0])};
            else
                exp_rd = {rd8(ba + 24'd3), rd8(ba + 24'd2), rd8(ba + 24'd1), rd8(ba)};
            chk(rsp_rdata == exp_rd, "R9 read word", rsp_rdata, exp_rd);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [21:0] wa;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !ale && rd_n && wr_n && ad_oe == 2'b00 && !rsp_valid,
            "R1 reset outputs", {26'd0, req_ready, ale, rd_n, wr_n, ad_oe}, 32'h2C);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !ale && rd_n && wr_n && !rsp_valid, "R1 after reset",
            {28'd0, req_ready, ale, rd_n, wr_n}, 32'hB);

        // Directed corner cases
        xfer(1'b0, 4'd3, 1'b0, 1'b1, 22'd0,  32'hA1B2C3D4); // R3 first word, one ALE
        xfer(1'b0, 4'd3, 1'b0, 1'b0, 22'd1,  32'h0);        // R4 sequential, no ALE
        xfer(1'b0, 4'd3, 1'b0, 1'b0, 22'd0,  32'h0);        // R4 backwards, ALE
        xfer(1'b0, 4'd3, 1'b0, 1'b1, 22'd63, 32'h11223344); // R4 non-sequential
        xfer(1'b0, 4'd3, 1'b0, 1'b0, 22'd64, 32'h0);        // R4 page crossing
        xfer(1'b0, 4'd3, 1'b0, 1'b0, 22'd63, 32'h0);        // R3 readback
        xfer(1'b1, 4'd3, 1'b0, 1'b1, 22'd65, 32'hDEADBEEF); // R6 mode switch, R5
        xfer(1'b1, 4'd3, 1'b0, 1'b0, 22'd65, 32'h0);        // R5 readback
        xfer(1'b1, 4'd3, 1'b0, 1'b0, 22'd66, 32'h0);        // R5 never skipped
        xfer(1'b0, 4'd3, 1'b0, 1'b0, 22'd67, 32'h0);        // R6 back to byte mode
        xfer(1'b0, 4'd0, 1'b1, 1'b1, 22'd68, 32'h5566AA99); // R7 zero acts as one, R8
        xfer(1'b0, 4'd15, 1'b1, 1'b0, 22'd68, 32'h0);       // R7 long phase
        xfer(1'b1, 4'd1, 1'b1, 1'b0, 22'd200, 32'h0);       // R8 halfword hold

        // Constrained random traffic
        wa = 22'd120;
        for (int i = 0; i < 200; i++) begin
            logic wide, hold, wr;
            logic [3:0] dur;
            wide = ($urandom % 4) == 0;
            hold = $urandom % 2;
            wr   = $urandom % 2;
            dur  = 4'($urandom % 16);
            if (($urandom % 5) == 0) wa = 22'($urandom % 4096);
            else                     wa = wa + 22'd1;
            xfer(wide, dur, hold, wr, wa, $urandom);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule